// File: doc/BRIEF.md
# Zero-Register Paired-Access Register File

This block is the general-purpose register store of a shader-style core. Each register is 32 bits wide and has no type: whether a word is an integer, a float or a pair of halves is decided only by the operation that consumes it. Registers are selected by an 8-bit index. The lowest indices hold storage. Index 254 is unimplemented, and index 255 is a hardwired zero register: it always reads as zero and silently discards writes.

There are two read ports and one write port. Any port can move either a single register or two adjacent registers in one access. A pair access addresses registers i and i+1, with i in the low half of the 64-bit bus. This is how 64-bit operands are fetched and how multi-word results are stored.

Reads are combinational. A write lands on the next rising clock edge, but any read in the same cycle that names an element being written sees the new value at once.

Top module: `zrf_regfile`

## Requirements
- R1: After an active-low reset, every register reads as zero on both read ports.
- R2: A read whose element index is 255 returns zero in that element.
- R3: A write aimed at index 255 leaves every stored register unchanged.
- R4: Index 254 holds no storage: reads of it return zero, and writes to it are discarded.
- R5: A single write stores wr_data[31:0] at wr_idx. A single read returns the register in rd_data[31:0], with rd_data[63:32] equal to zero.
- R6: A pair read at index i returns register i in bits [31:0] and register i+1 in bits [63:32].
- R7: A pair write at index i stores wr_data[31:0] into register i and wr_data[63:32] into register i+1, in the same clock edge.
- R8: In a pair access, the upper element at index 254 or higher (including 256, from a base of 255) reads as zero and is not written; the lower element is still handled normally.
- R9: When a read element has the same index as a live element being written in that cycle, the read returns the write data for that element, on each read port and for each half.
- R10: While wr_en is low, no register changes, whatever wr_idx, wr_pair and wr_data hold.
- R11: The two read ports work independently: each returns its own index and width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| rd0_idx | input | 8 | Read port 0 base index |
| rd0_pair | input | 1 | Read port 0 reads two adjacent registers when high |
| rd0_data | output | 64 | Read port 0 data; upper word is zero for a single read |
| rd1_idx | input | 8 | Read port 1 base index |
| rd1_pair | input | 1 | Read port 1 reads two adjacent registers when high |
| rd1_data | output | 64 | Read port 1 data; upper word is zero for a single read |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 8 | Write base index |
| wr_pair | input | 1 | Write two adjacent registers when high |
| wr_data | input | 64 | Write data; lower word goes to the base index |

## Verification
The hardest case to reach from the ports is a pair read that overlaps a pair write by one element. In that case only one half of the read is bypassed and the other half comes from storage, which may itself be at the top edge of the usable range. Directed steps place write bases and read bases one index apart, at both ends of the index space (around 19–21 and around 252–255). A randomized phase then draws indices mostly from a narrow low window and a narrow top window. This makes such overlaps, and zero-register collisions, frequent. Every result is compared against a reference model kept in the bench.

// File: rtl/zrf_pkg.sv
package zrf_pkg;

  // Index of one element of an access: base plus slot (0 = low word, 1 = high word).
  function automatic int unsigned elem_index(int unsigned base, int unsigned slot);
    return base + slot;
  endfunction

  // An element takes part in an access if it is wanted and falls inside storage.
  function automatic bit elem_live(int unsigned idx, int unsigned nregs, bit wanted);
    return wanted && (idx < nregs);
  endfunction

endpackage

// File: rtl/zrf_wr_decode.sv
module zrf_wr_decode #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 254
) (
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic                               wr_pair,
  input  logic [2*DATA_W-1:0]                wr_data,
  output logic [1:0][IDX_W:0]                el_idx,
  output logic [1:0]                         el_live,
  output logic [1:0][DATA_W-1:0]             el_data,
  output logic [NUM_REGS-1:0]                reg_we,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    reg_wd
);

  for (genvar k = 0; k < 2; k++) begin : g_elem
    assign el_idx[k]  = (IDX_W+1)'(zrf_pkg::elem_index(int'(wr_idx), k));
    assign el_live[k] = zrf_pkg::elem_live(int'(el_idx[k]), NUM_REGS,
                                           wr_en && ((k == 0) || wr_pair));
    assign el_data[k] = wr_data[k*DATA_W +: DATA_W];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit_lo, hit_hi;
    assign hit_lo    = el_live[0] && (el_idx[0] == (IDX_W+1)'(i));
    assign hit_hi    = el_live[1] && (el_idx[1] == (IDX_W+1)'(i));
    assign reg_we[i] = hit_lo || hit_hi;
    assign reg_wd[i] = hit_lo ? el_data[0] : el_data[1];
  end

endmodule

// File: rtl/zrf_storage.sv
module zrf_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 254
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REGS-1:0]             reg_we,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] reg_wd,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[i] <= '0;
      else if (reg_we[i]) regs_q[i] <= reg_wd[i];
    end
  end

endmodule

// File: rtl/zrf_rd_port.sv
module zrf_rd_port #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 254
) (
  input  logic [IDX_W-1:0]                rd_idx,
  input  logic                            rd_pair,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
  input  logic [1:0][IDX_W:0]             wr_el_idx,
  input  logic [1:0]                      wr_el_live,
  input  logic [1:0][DATA_W-1:0]          wr_el_data,
  output logic [2*DATA_W-1:0]             rd_data
);

  for (genvar k = 0; k < 2; k++) begin : g_elem
    logic [IDX_W:0]    idx;
    logic              live;
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] value;

    assign idx  = (IDX_W+1)'(zrf_pkg::elem_index(int'(rd_idx), k));
    assign live = zrf_pkg::elem_live(int'(idx), NUM_REGS, (k == 0) || rd_pair);

    always_comb begin
      stored = '0;
      for (int j = 0; j < NUM_REGS; j++) begin
        if (idx == (IDX_W+1)'(j)) stored = regs_q[j];
      end
    end

    always_comb begin
      value = stored;
      for (int w = 0; w < 2; w++) begin
        if (wr_el_live[w] && (wr_el_idx[w] == idx)) value = wr_el_data[w];
      end
    end

    assign rd_data[k*DATA_W +: DATA_W] = live ? value : '0;
  end

endmodule

// File: rtl/zrf_regfile.sv
module zrf_regfile #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 254
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd0_idx,
  input  logic                rd0_pair,
  output logic [2*DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]    rd1_idx,
  input  logic                rd1_pair,
  output logic [2*DATA_W-1:0] rd1_data,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_pair,
  input  logic [2*DATA_W-1:0] wr_data
);

  localparam int NUM_RD = 2;

  logic [1:0][IDX_W:0]             wr_el_idx;
  logic [1:0]                      wr_el_live;
  logic [1:0][DATA_W-1:0]          wr_el_data;
  logic [NUM_REGS-1:0]             reg_we;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_wd;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  logic [NUM_RD-1:0][IDX_W-1:0]    rp_idx;
  logic [NUM_RD-1:0]               rp_pair;
  logic [NUM_RD-1:0][2*DATA_W-1:0] rp_data;

  assign rp_idx  = {rd1_idx, rd0_idx};
  assign rp_pair = {rd1_pair, rd0_pair};
  assign rd0_data = rp_data[0];
  assign rd1_data = rp_data[1];

  zrf_wr_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) wdec_i (
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_pair (wr_pair),
    .wr_data (wr_data),
    .el_idx  (wr_el_idx),
    .el_live (wr_el_live),
    .el_data (wr_el_data),
    .reg_we  (reg_we),
    .reg_wd  (reg_wd)
  );

  zrf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .reg_we (reg_we),
    .reg_wd (reg_wd),
    .regs_q (regs_q)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rport
    zrf_rd_port #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) rport_i (
      .rd_idx     (rp_idx[p]),
      .rd_pair    (rp_pair[p]),
      .regs_q     (regs_q),
      .wr_el_idx  (wr_el_idx),
      .wr_el_live (wr_el_live),
      .wr_el_data (wr_el_data),
      .rd_data    (rp_data[p])
    );
  end

endmodule

// File: rtl/zrf_regfile_chk.sv
module zrf_regfile_chk #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 254
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [IDX_W-1:0]                rd0_idx,
  input logic                            rd0_pair,
  input logic [2*DATA_W-1:0]             rd0_data,
  input logic [IDX_W-1:0]                rd1_idx,
  input logic                            rd1_pair,
  input logic [2*DATA_W-1:0]             rd1_data,
  input logic                            wr_en,
  input logic [IDX_W-1:0]                wr_idx,
  input logic                            wr_pair,
  input logic [2*DATA_W-1:0]             wr_data,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
  input logic [1:0]                      wr_el_live
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '1;

  // R2
  zero_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_idx == ZERO_IDX) |-> (rd0_data[DATA_W-1:0] == '0));

  // R3
  zero_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == ZERO_IDX)) |=> $stable(regs_q));

  // R5
  single_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd0_pair |-> (rd0_data[2*DATA_W-1:DATA_W] == '0));

  // R5
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_el_live[0] && !wr_pair) |=> (regs_q[$past(wr_idx)] == $past(wr_data[DATA_W-1:0])));

  // R8
  hi_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_pair && (({1'b0, rd1_idx} + 1'b1) >= (IDX_W+1)'(NUM_REGS)))
      |-> (rd1_data[2*DATA_W-1:DATA_W] == '0));

  // R9
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_pair && (int'(wr_idx) < NUM_REGS) && (rd0_idx == wr_idx))
      |-> (rd0_data[DATA_W-1:0] == wr_data[DATA_W-1:0]));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));

endmodule

bind zrf_regfile zrf_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd0_idx    (rd0_idx),
  .rd0_pair   (rd0_pair),
  .rd0_data   (rd0_data),
  .rd1_idx    (rd1_idx),
  .rd1_pair   (rd1_pair),
  .rd1_data   (rd1_data),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_pair    (wr_pair),
  .wr_data    (wr_data),
  .regs_q     (regs_q),
  .wr_el_live (wr_el_live)
);

// File: tb/zrf_regfile_tb_top.sv
module zrf_regfile_tb_top;

  localparam int USABLE = 254;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rd0_idx, rd1_idx, wr_idx;
  logic        rd0_pair, rd1_pair, wr_en, wr_pair;
  logic [63:0] rd0_data, rd1_data, wr_data;

  always #5 clk = ~clk;

  zrf_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(rd0_idx), .rd0_pair(rd0_pair), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_pair(rd1_pair), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pair(wr_pair), .wr_data(wr_data)
  );

  typedef struct {
    string       req;
    logic [63:0] e0;
    logic [63:0] e1;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model [0:255];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;
  event        sample_ev;

  // Expected value of one 32-bit element, restated from the requirements.
  function automatic logic [31:0] elem_exp(int idx, bit we, int widx, bit wpair, logic [63:0] wd);
    if (idx >= USABLE) return 32'h0;                          // R2 R4 R8
    if (we && idx == widx) return wd[31:0];                   // R9
    if (we && wpair && idx == widx + 1) return wd[63:32];     // R9
    return model[idx];
  endfunction

  function automatic logic [63:0] read_exp(int idx, bit pair, bit we, int widx, bit wpair,
                                           logic [63:0] wd);
    logic [31:0] hi;
    hi = pair ? elem_exp(idx + 1, we, widx, wpair, wd) : 32'h0;
    return {hi, elem_exp(idx, we, widx, wpair, wd)};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; pushes the expected reads, then updates the model.
  task automatic op(string req, int r0, bit p0, int r1, bit p1,
                    bit we, int wi, bit wp, logic [63:0] wd);
    exp_t it;
    @(negedge clk);
    rd0_idx = 8'(r0); rd0_pair = p0;
    rd1_idx = 8'(r1); rd1_pair = p1;
    wr_en = we; wr_idx = 8'(wi); wr_pair = wp; wr_data = wd;
    it.req = req;
    it.e0  = read_exp(r0, p0, we, wi, wp, wd);
    it.e1  = read_exp(r1, p1, we, wi, wp, wd);
    sb_q.push_back(it);
    ->sample_ev;
    @(posedge clk);
    if (we) begin
      if (wi < USABLE) model[wi] = wd[31:0];
      if (wp && wi + 1 < USABLE) model[wi + 1] = wd[63:32];
    end
  endtask

  task automatic rd(string req, int r0, bit p0, int r1, bit p1);
    op(req, r0, p0, r1, p1, 1'b0, 0, 1'b0, 64'h0);
  endtask

  // Monitor: compares results away from the clock edge.
  initial begin
    forever begin
      exp_t it;
      @(sample_ev);
      #1;
      it = sb_q.pop_front();
      check({it.req, " port0"}, rd0_data, it.e0);
      check({it.req, " port1"}, rd1_data, it.e1);
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 32'h0;
    rst_n = 1'b0;
    rd0_idx = '0; rd1_idx = '0; rd0_pair = 0; rd1_pair = 0;
    wr_en = 0; wr_idx = '0; wr_pair = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1", 0, 1'b1, 100, 1'b1);
    rd("R1", 252, 1'b1, 7, 1'b0);

    // R5 single write then read; R11 different widths on the two ports
    op("R5", 0, 0, 0, 0, 1'b1, 5, 1'b0, 64'hDEAD_BEEF_1234_5678);
    rd("R5", 5, 1'b0, 4, 1'b1);
    rd("R11", 4, 1'b1, 5, 1'b0);

    // R2 R3 zero register: write ignored, read zero
    op("R3", 0, 0, 0, 0, 1'b1, 255, 1'b0, 64'h1111_2222_3333_4444);
    op("R3", 0, 0, 0, 0, 1'b1, 255, 1'b1, 64'h5555_6666_7777_8888);
    rd("R2", 255, 1'b0, 255, 1'b1);
    rd("R3", 0, 1'b1, 1, 1'b0);

    // R4 index 254 unimplemented
    op("R4", 0, 0, 0, 0, 1'b1, 254, 1'b0, 64'h0000_0000_CAFE_F00D);
    rd("R4", 254, 1'b0, 253, 1'b1);

    // R7 pair write, R6 pair read
    op("R7", 0, 0, 0, 0, 1'b1, 10, 1'b1, 64'hAAAA_0011_BBBB_0010);
    rd("R6", 10, 1'b1, 11, 1'b0);
    rd("R7", 9, 1'b1, 11, 1'b1);

    // R8 pair at the top edge
    op("R8", 0, 0, 0, 0, 1'b1, 253, 1'b1, 64'h9999_0254_7777_0253);
    rd("R8", 253, 1'b1, 252, 1'b1);
    op("R8", 0, 0, 0, 0, 1'b1, 254, 1'b1, 64'h4242_4242_4343_4343);
    rd("R8", 254, 1'b1, 253, 1'b1);

    // R9 bypass: single and pair, partial overlap, both ports
    op("R9", 20, 1'b0, 20, 1'b1, 1'b1, 20, 1'b0, 64'h0_0000_0000_ABCD_0020);
    op("R9", 19, 1'b1, 21, 1'b1, 1'b1, 20, 1'b1, 64'h2121_2121_2020_2020);
    op("R9", 253, 1'b1, 252, 1'b1, 1'b1, 253, 1'b0, 64'h0000_0000_5353_5353);
    rd("R9", 19, 1'b1, 20, 1'b1);

    // R10 wr_en low
    op("R10", 5, 1'b0, 10, 1'b1, 1'b0, 5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R10", 5, 1'b1, 10, 1'b1);

    // R11 randomized, indices clustered at both ends
    for (int n = 0; n < 400; n++) begin
      int a, b, c;
      a = ($urandom_range(0, 1) != 0) ? int'($urandom_range(0, 12)) : int'($urandom_range(248, 255));
      b = ($urandom_range(0, 1) != 0) ? int'($urandom_range(0, 12)) : int'($urandom_range(248, 255));
      c = ($urandom_range(0, 1) != 0) ? int'($urandom_range(0, 12)) : int'($urandom_range(248, 255));
      op("R11", a, 1'($urandom_range(0, 1)), b, 1'($urandom_range(0, 1)),
         1'($urandom_range(0, 1)), c, 1'($urandom_range(0, 1)), {$urandom, $urandom});
    end

    // R1 reset clears everything written
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) model[i] = 32'h0;
    rd("R1", 10, 1'b1, 5, 1'b0);
    rd("R1", 252, 1'b1, 0, 1'b1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule